// File: doc/BRIEF.md
# Do-While Loop Sequencer

This block drives an external loop-body datapath with do-while semantics. A start pulse in the idle state begins a run. When the loop-carried register is configured as initialised, the block first spends one cycle loading its initial value. It then pulses `body_start_o` and waits for `body_done_i`. In the cycle of `body_done_i` it captures the value the body returns and samples the condition input. If the run goes on, the next pass starts after a fixed gap of two idle cycles. Otherwise the run ends with a one-cycle `done_o` pulse.

The block exposes a signed iteration index that saturates instead of wrapping. It also exposes the loop-carried value, which the body reads during the next pass. Control is a small finite state machine. The index counter and the carried-value register are separate submodules. `rst_n` is an asynchronous active-low reset whose release must already be synchronous to `clk`.

Top module: `loop_seq`

## Requirements
- R1: While `rst_n` is low, and after its release, `busy_o`, `done_o` and `body_start_o` are 0 and `index_o` is 0.
- R2: A start accepted in idle with `USE_INIT=1` loads `init_val_i` into `carry_o` and raises `body_start_o` two cycles after the start cycle. With `USE_INIT=0` the load cycle is skipped and `body_start_o` rises in the cycle after the start.
- R3: Every accepted start runs the body at least once, whatever level the condition input has.
- R4: The condition input is sampled only in a cycle where `body_done_i` is high while the body is running. At all other times its level has no effect.
- R5: After a continuing `body_done_i`, `body_start_o` is low for exactly two cycles and then high.
- R6: `index_o` is 0 during the first pass. It rises by one at each continuing `body_done_i` and is cleared at each accepted start.
- R7: `index_o` is signed, `IDX_W` bits wide (default 32). It saturates at 2^(IDX_W-1)-1 and never wraps.
- R8: `carry_o` takes `body_val_i` at every `body_done_i` of a running pass. After the run it keeps the final value until the next start.
- R9: With `STOP_ON_TRUE=1` a high condition ends the loop. With `STOP_ON_TRUE=0` a low condition ends it.
- R10: In the cycle after the terminating `body_done_i`, `done_o` is high for exactly one cycle and `busy_o` is low.
- R11: A start pulse while `busy_o` is high is ignored. The run, its index and its timing continue unchanged.
- R12: `body_start_o` is a single-cycle pulse for each pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| start_i | input | 1 | Start request, honoured only when idle |
| init_val_i | input | DATA_W | Initial value for the loop-carried register |
| body_start_o | output | 1 | One-cycle pulse launching a body pass |
| body_done_i | input | 1 | Body reports the end of its pass |
| body_cond_i | input | 1 | Loop condition, valid with `body_done_i` |
| body_val_i | input | DATA_W | Value produced by the body, valid with `body_done_i` |
| carry_o | output | DATA_W | Loop-carried value fed to the body |
| index_o | output | IDX_W | Signed saturating iteration index |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |

## Verification
The assertions check several properties on every cycle:
- the single-cycle shape of `body_start_o` and `done_o`;
- the exact two-cycle gap after a continuing pass;
- busy rising after an accepted start;
- the index never decreasing except on a clear;
- a stable index when a start arrives mid-run;
- the carried value holding between loads and captures.

Other behaviours need directed scenarios in the bench:
- whether a stop condition at the first pass still yields exactly one pass;
- whether the condition is ignored outside the done cycle;
- the absolute launch latency with and without the load cycle;
- the saturation value itself;
- the inverted condition polarity.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_LAUNCH,
    ST_WAIT,
    ST_GAP
  } seq_state_e;

  // fixed overhead cycles between the end of one pass and the next launch
  localparam int unsigned GAP_CYC = 2;

endpackage

// File: rtl/loop_seq_ctrl.sv
module loop_seq_ctrl
  import loop_seq_pkg::*;
#(
  parameter bit USE_INIT     = 1'b1,
  parameter bit STOP_ON_TRUE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic body_done_i,
  input  logic body_cond_i,
  output logic body_start_o,
  output logic busy_o,
  output logic done_o,
  output logic load_init_o,
  output logic capture_o,
  output logic clr_idx_o,
  output logic inc_idx_o
);

  localparam int unsigned CNT_W = $clog2(GAP_CYC + 1);

  seq_state_e       st_q, st_n;
  logic [CNT_W-1:0] gap_q, gap_n;
  logic             done_q, done_n;
  logic             stop_w;
  logic             end_pass_w;

  generate
    if (STOP_ON_TRUE) begin : g_stop_high
      assign stop_w = body_cond_i;
    end else begin : g_stop_low
      assign stop_w = ~body_cond_i;
    end
  endgenerate

  assign end_pass_w = (st_q == ST_WAIT) && body_done_i;

  always_comb begin
    st_n  = st_q;
    gap_n = gap_q;
    case (st_q)
      ST_IDLE:   if (start_i) st_n = USE_INIT ? ST_INIT : ST_LAUNCH;
      ST_INIT:   st_n = ST_LAUNCH;
      ST_LAUNCH: st_n = ST_WAIT;
      ST_WAIT: begin
        if (body_done_i) begin
          if (stop_w) begin
            st_n = ST_IDLE;
          end else begin
            st_n  = ST_GAP;
            gap_n = CNT_W'(GAP_CYC - 1);
          end
        end
      end
      ST_GAP: begin
        if (gap_q == '0) st_n = ST_LAUNCH;
        else             gap_n = gap_q - 1'b1;
      end
      default:   st_n = ST_IDLE;
    endcase
  end

  assign done_n = end_pass_w && stop_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      gap_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      gap_q  <= gap_n;
      done_q <= done_n;
    end
  end

  assign body_start_o = (st_q == ST_LAUNCH);
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign load_init_o  = (st_q == ST_INIT);
  assign capture_o    = end_pass_w;
  assign clr_idx_o    = (st_q == ST_IDLE) && start_i;
  assign inc_idx_o    = end_pass_w && !stop_w;

  p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    body_start_o |=> !body_start_o);

  p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_idx_o |=> !body_start_o ##1 !body_start_o ##1 body_start_o);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_first_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_idx_o |=> busy_o);

endmodule

// File: rtl/loop_seq_index.sv
module loop_seq_index #(
  parameter int unsigned IDX_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    inc_i,
  output logic signed [IDX_W-1:0] idx_o
);

  localparam logic signed [IDX_W-1:0] IDX_MAX = {1'b0, {(IDX_W-1){1'b1}}};

  logic signed [IDX_W-1:0] idx_q, idx_n;

  always_comb begin
    idx_n = idx_q;
    if (clr_i)                        idx_n = '0;
    else if (inc_i && idx_q != IDX_MAX) idx_n = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_n;
  end

  assign idx_o = idx_q;

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (idx_o >= $past(idx_o)));

  p_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (idx_o == '0));

endmodule

// File: rtl/loop_seq_carry.sv
module loop_seq_carry #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] init_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] body_i,
  output logic [DATA_W-1:0] carry_o
);

  logic [DATA_W-1:0] carry_q, carry_n;
  logic              en_w;

  assign en_w = load_i | cap_i;

  always_comb begin
    carry_n = carry_q;
    if (load_i)     carry_n = init_i;
    else if (cap_i) carry_n = body_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    carry_q <= '0;
    else if (en_w) carry_q <= carry_n;
  end

  assign carry_o = carry_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_w |=> $stable(carry_o));

endmodule

// File: rtl/loop_seq.sv
module loop_seq #(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned IDX_W        = 32,
  parameter bit          USE_INIT     = 1'b1,
  parameter bit          STOP_ON_TRUE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [DATA_W-1:0]       init_val_i,
  output logic                    body_start_o,
  input  logic                    body_done_i,
  input  logic                    body_cond_i,
  input  logic [DATA_W-1:0]       body_val_i,
  output logic [DATA_W-1:0]       carry_o,
  output logic signed [IDX_W-1:0] index_o,
  output logic                    busy_o,
  output logic                    done_o
);

  logic load_w, cap_w, clr_w, inc_w;

  loop_seq_ctrl #(
    .USE_INIT    (USE_INIT),
    .STOP_ON_TRUE(STOP_ON_TRUE)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .body_done_i (body_done_i),
    .body_cond_i (body_cond_i),
    .body_start_o(body_start_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .load_init_o (load_w),
    .capture_o   (cap_w),
    .clr_idx_o   (clr_w),
    .inc_idx_o   (inc_w)
  );

  loop_seq_index #(.IDX_W(IDX_W)) index_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr_i(clr_w),
    .inc_i(inc_w),
    .idx_o(index_o)
  );

  loop_seq_carry #(.DATA_W(DATA_W)) carry_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_w),
    .init_i (init_val_i),
    .cap_i  (cap_w),
    .body_i (body_val_i),
    .carry_o(carry_o)
  );

  p_ignore_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !body_done_i) |=> $stable(index_o));

endmodule

// File: tb/loop_seq_tb.sv
module loop_seq_tb_top;

  localparam int DW = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          start1 = 0, done1 = 0, cond1 = 0;
  logic [DW-1:0] init1 = '0, val1 = '0;
  logic          bs1, busy1, dn1;
  logic [DW-1:0] carry1;
  logic signed [IW-1:0] idx1;

  logic          start2 = 0, done2 = 0, cond2 = 0;
  logic [DW-1:0] init2 = '0, val2 = '0;
  logic          bs2, busy2, dn2;
  logic [DW-1:0] carry2;
  logic signed [IW-1:0] idx2;

  int checks = 0;
  int errors = 0;

  loop_seq #(.DATA_W(DW), .IDX_W(IW), .USE_INIT(1'b1), .STOP_ON_TRUE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start1), .init_val_i(init1),
    .body_start_o(bs1), .body_done_i(done1), .body_cond_i(cond1),
    .body_val_i(val1), .carry_o(carry1), .index_o(idx1),
    .busy_o(busy1), .done_o(dn1));

  loop_seq #(.DATA_W(DW), .IDX_W(IW), .USE_INIT(1'b0), .STOP_ON_TRUE(1'b0)) dut2_i (
    .clk(clk), .rst_n(rst_n), .start_i(start2), .init_val_i(init2),
    .body_start_o(bs2), .body_done_i(done2), .body_cond_i(cond2),
    .body_val_i(val2), .carry_o(carry2), .index_o(idx2),
    .busy_o(busy2), .done_o(dn2));

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy1), 0);
    chk("R1 done", int'(dn1), 0);
    chk("R1 body_start", int'(bs1), 0);
    chk("R1 index", int'(idx1), 0);
    chk("R1 busy2", int'(busy2), 0);
  endtask

  // single pass where the condition says stop already at the first pass
  task automatic t_single();
    init1 = 8'h5A;
    start1 = 1; step(); start1 = 0;
    chk("R2 busy after start", int'(busy1), 1);
    chk("R2 no launch during load", int'(bs1), 0);
    step();
    chk("R2 launch", int'(bs1), 1);
    chk("R2 init loaded", int'(carry1), 8'h5A);
    chk("R6 index first pass", int'(idx1), 0);
    step();
    chk("R12 pulse width", int'(bs1), 0);
    done1 = 1; cond1 = 1; val1 = 8'd33;
    step(); done1 = 0; cond1 = 0;
    chk("R3 one pass then done", int'(dn1), 1);
    chk("R10 busy low with done", int'(busy1), 0);
    chk("R8 value captured", int'(carry1), 33);
    step();
    chk("R10 done single cycle", int'(dn1), 0);
  endtask

  task automatic t_multi();
    init1 = 8'h07;
    start1 = 1; step(); start1 = 0;
    step();
    for (int k = 0; k < 3; k++) begin
      chk("R12 launch", int'(bs1), 1);
      chk("R6 index", int'(idx1), k);
      step();
      chk("R12 low after launch", int'(bs1), 0);
      cond1 = 1; start1 = 1;          // stop level without done, start while busy
      step(); start1 = 0;
      chk("R4 cond ignored without done", int'(busy1), 1);
      chk("R11 start ignored", int'(idx1), k);
      done1 = 1; cond1 = (k == 2); val1 = 8'(k + 10);
      step(); done1 = 0; cond1 = 0;
      if (k < 2) begin
        chk("R6 index step", int'(idx1), k + 1);
        chk("R5 gap cycle 1", int'(bs1), 0);
        step();
        chk("R5 gap cycle 2", int'(bs1), 0);
        step();
      end else begin
        chk("R10 done after last", int'(dn1), 1);
        chk("R8 final value", int'(carry1), 12);
      end
    end
    for (int j = 0; j < 4; j++) step();
    chk("R8 value held", int'(carry1), 12);
    chk("R6 index held", int'(idx1), 2);
    chk("R10 idle", int'(busy1), 0);
  endtask

  task automatic t_sat();
    start1 = 1; step(); start1 = 0;
    step();
    for (int k = 0; k < 10; k++) begin
      step();
      done1 = 1; cond1 = (k == 9); val1 = 8'(k);
      step(); done1 = 0; cond1 = 0;
      if (k < 9) begin
        chk("R7 saturating index", int'(idx1), (k + 1 > 7) ? 7 : k + 1);
        step(); step();
      end
    end
    chk("R7 no wrap at end", int'(idx1), 7);
    chk("R10 sat run done", int'(dn1), 1);
  endtask

  task automatic t_polarity();
    start2 = 1; step(); start2 = 0;
    chk("R2 no load cycle", int'(bs2), 1);
    step();
    done2 = 1; cond2 = 0; val2 = 8'd44;
    step(); done2 = 0;
    chk("R9 low cond stops", int'(dn2), 1);
    chk("R3 single pass", int'(busy2), 0);
    chk("R8 capture dut2", int'(carry2), 44);
    start2 = 1; step(); start2 = 0;
    chk("R8 no init load", int'(carry2), 44);
    step();
    done2 = 1; cond2 = 1; val2 = 8'd45;
    step(); done2 = 0; cond2 = 0;
    chk("R9 high cond continues", int'(busy2), 1);
    chk("R6 dut2 index", int'(idx2), 1);
    step(); step();
    chk("R5 dut2 relaunch", int'(bs2), 1);
    step();
    done2 = 1; cond2 = 0; val2 = 8'd46;
    step(); done2 = 0;
    chk("R9 stop after two", int'(dn2), 1);
    chk("R8 final dut2", int'(carry2), 46);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step();
    t_reset();
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_single();
    step();
    t_multi();
    step();
    t_sat();
    step();
    t_polarity();
    step();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule